// File: doc/BRIEF.md
# Programmable-Modulus MASH Fractional-N Divide Controller

The block works out, once per phase-detector reference cycle, the integer modulus for a fractional-N feedback divider. Over time the divide value averages to N + num/den. The fractional part comes from a cascade of up to four first-order accumulators. Each accumulator wraps modulo a programmed denominator that can be any 32-bit value from 1 upward, so it is not tied to a power of two. This makes exact rational ratios possible, such as one third or seven thousandths. A difference-filter cascade combines the accumulator carries into a signed correction, and the correction is added to N.

The integration logic pulses `ref_stb_i` once per reference cycle. One cycle later the divider reads `div_o`, which is qualified by `valid_o`. Bringing up a new setting takes three steps: change the configuration, pulse `mod_rst_i` to clear all modulator history, then start strobing again. `cfg_err_o` is combinational and reports a setting that cannot be used. While it is high, the block passes N through unchanged and keeps the modulator cleared.

Top module: `frac_mash_ctrl`

## Requirements
- R1: While `rst_ni` is low, `div_o` reads 0 and `valid_o` reads 0.
- R2: A strobe accepted on a clock edge (with `mod_rst_i` low) updates `div_o` and raises `valid_o` for exactly the following cycle. In every other cycle `valid_o` is 0 and `div_o` holds its value.
- R3: `order_i` = 0 is integer mode. The output is N on every strobe, and `num_i` and `den_i` are ignored, even when num ≥ den or den = 0.
- R4: Each enabled stage adds its input to its state. When the sum is ≥ den, den is subtracted and a carry of 1 is emitted. Stage 1 adds `num_i`, and each later stage adds the new residual of the stage before it. This holds for any den up to 4294967295.
- R5: With carries c1..c4 and only the first `order_i` stages enabled, the correction is c1 + Δ(c2 + Δ(c3 + Δc4)), where Δx = x − (x at the previous strobe). The output is N plus this correction, so an order m correction lies within [−(2^(m−1)−1), 2^(m−1)].
- R6: In order 1, the sum of the outputs over L strobes after a modulator reset is L·N + (L·num − r)/den, with 0 ≤ r < den. The sum is exact when L is a multiple of den.
- R7: In orders 2 to 4, the value den·(sum − L·N) − L·num stays within (−den·2^(m−2), den·2^(m−2)].
- R8: When den = 1 and num = 0, the output is N for any order.
- R9: When the order is nonzero and either den = 0 or num ≥ den, `cfg_err_o` is 1 and every strobe outputs N.
- R10: `cfg_err_o` is 1 when N < 28 + (2^(m−1) − 1) for order m ≥ 1, or when N < 28 for order 0. The output is still N.
- R11: Order codes 5 to 7 raise `cfg_err_o` and output N.
- R12: `mod_rst_i` clears all accumulators and filter history, so the sequence that follows repeats exactly. A strobe in the same cycle as `mod_rst_i` is ignored: no valid pulse, and `div_o` is unchanged.
- R13: N is a 19-bit field. `div_o` is 20 bits wide, so N = 524287 plus the largest correction is carried without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_stb_i | input | 1 | One pulse per reference cycle |
| mod_rst_i | input | 1 | Synchronous clear of modulator history |
| n_i | input | 19 | Integer part N |
| num_i | input | 32 | Fractional numerator |
| den_i | input | 32 | Fractional denominator (modulus) |
| order_i | input | 3 | Modulator order, 0 to 4 |
| div_o | output | 20 | Instantaneous divide value |
| valid_o | output | 1 | High for the cycle after an accepted strobe |
| cfg_err_o | output | 1 | Configuration not usable |

## Verification
`cfg_err_o` depends only on the inputs, so it is due in the same cycle the configuration changes. The bench samples it one time step after driving the inputs. `div_o` and `valid_o` go through a single register, so they are due one cycle after the edge that captures the strobe. The bench raises the strobe on a falling edge, lowers it on the next falling edge, and samples there. At every idle falling edge in between, it confirms that `valid_o` is low and `div_o` is unchanged. A bench model steps its own accumulators and an expanded difference sum on the same strobes, resets its history on each modulator reset, and predicts every output value. Running-sum bounds are checked at the end of each run.

// File: rtl/frac_mash_pkg.sv
package frac_mash_pkg;
  // magnitude of the most negative correction for a given order
  function automatic int neg_reach(input int order);
    return (order == 0) ? 0 : ((1 << (order - 1)) - 1);
  endfunction
endpackage

// File: rtl/frac_mash_acc.sv
module frac_mash_acc #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         clr_i,
  input  logic [W-1:0] add_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  logic [W-1:0] st_q;
  logic [W:0]   sum_w;
  logic         wrap_w;

  assign sum_w   = {1'b0, st_q} + {1'b0, add_i};
  assign wrap_w  = sum_w >= {1'b0, den_i};
  assign res_o   = W'(wrap_w ? sum_w - {1'b0, den_i} : sum_w);
  assign carry_o = wrap_w & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '0;
    else if (clr_i)  st_q <= '0;
    else if (step_i) st_q <= res_o;
  end

  a_r4_residual_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clr_i && st_q < den_i && add_i < den_i |=> st_q < $past(den_i));
  a_r12_clear_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> st_q == '0);
endmodule

// File: rtl/frac_mash_shaper.sv
module frac_mash_shaper #(
  parameter int STAGES = 4,
  parameter int CORR_W = STAGES + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_i,
  input  logic                     clr_i,
  input  logic [STAGES-1:0]        carry_i,
  output logic signed [CORR_W-1:0] corr_o
);
  localparam int CMAX = 1 << (STAGES - 1);

  // j = 0 handles the last stage; each level adds the difference of the one above
  for (genvar j = 0; j < STAGES; j++) begin : g_lvl
    logic signed [CORR_W-1:0] y_s;
    logic signed [CORR_W-1:0] c_s;
    assign c_s = signed'(CORR_W'(carry_i[STAGES-1-j]));
    if (j == 0) begin : g_top
      assign y_s = c_s;
    end else begin : g_dif
      logic signed [CORR_W-1:0] yd_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     yd_q <= '0;
        else if (clr_i)  yd_q <= '0;
        else if (step_i) yd_q <= g_lvl[j-1].y_s;
      end
      assign y_s = c_s + g_lvl[j-1].y_s - yd_q;
    end
  end

  assign corr_o = g_lvl[STAGES-1].y_s;

  a_r5_corr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o >= -(CMAX - 1) && corr_o <= CMAX);
endmodule

// File: rtl/frac_mash_cfg.sv
module frac_mash_cfg
  import frac_mash_pkg::*;
#(
  parameter int N_W    = 19,
  parameter int FRAC_W = 32,
  parameter int ORD_W  = 3,
  parameter int STAGES = 4,
  parameter int N_MIN  = 28
) (
  input  logic [N_W-1:0]    n_i,
  input  logic [FRAC_W-1:0] num_i,
  input  logic [FRAC_W-1:0] den_i,
  input  logic [ORD_W-1:0]  order_i,
  output logic              err_o,
  output logic [STAGES-1:0] stage_en_o
);
  logic bad_ord, n_low, frac_bad;

  always_comb begin
    bad_ord  = int'(order_i) > STAGES;
    n_low    = int'(n_i) < N_MIN + neg_reach(int'(order_i));
    frac_bad = (order_i != '0) && (den_i == '0 || num_i >= den_i);
    err_o    = bad_ord | n_low | frac_bad;
    for (int k = 0; k < STAGES; k++) stage_en_o[k] = int'(order_i) > k;
  end
endmodule

// File: rtl/frac_mash_ctrl.sv
module frac_mash_ctrl #(
  parameter int N_W    = 19,
  parameter int FRAC_W = 32,
  parameter int ORD_W  = 3,
  parameter int STAGES = 4,
  parameter int N_MIN  = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_stb_i,
  input  logic              mod_rst_i,
  input  logic [N_W-1:0]    n_i,
  input  logic [FRAC_W-1:0] num_i,
  input  logic [FRAC_W-1:0] den_i,
  input  logic [ORD_W-1:0]  order_i,
  output logic [N_W:0]      div_o,
  output logic              valid_o,
  output logic              cfg_err_o
);
  localparam int DIV_W  = N_W + 1;
  localparam int CORR_W = STAGES + 1;

  logic [STAGES-1:0]        stage_en, carry_w;
  logic [FRAC_W-1:0]        res_w [STAGES];
  logic                     take_w, step_w, hist_clr;
  logic signed [CORR_W-1:0] corr_w;
  logic [DIV_W-1:0]         div_nxt;

  frac_mash_cfg #(.N_W(N_W), .FRAC_W(FRAC_W), .ORD_W(ORD_W), .STAGES(STAGES),
                  .N_MIN(N_MIN)) u_cfg (
    .n_i, .num_i, .den_i, .order_i, .err_o(cfg_err_o), .stage_en_o(stage_en)
  );

  assign take_w   = ref_stb_i & ~mod_rst_i;
  assign hist_clr = mod_rst_i | cfg_err_o;
  assign step_w   = take_w & ~cfg_err_o;

  for (genvar k = 0; k < STAGES; k++) begin : g_st
    logic [FRAC_W-1:0] add_w;
    if (k == 0) begin : g_first
      assign add_w = num_i;
    end else begin : g_next
      assign add_w = res_w[k-1];
    end
    frac_mash_acc #(.W(FRAC_W)) u_acc (
      .clk_i, .rst_ni, .step_i(step_w), .clr_i(hist_clr | ~stage_en[k]),
      .add_i(add_w), .den_i, .res_o(res_w[k]), .carry_o(carry_w[k])
    );
  end

  frac_mash_shaper #(.STAGES(STAGES), .CORR_W(CORR_W)) u_shp (
    .clk_i, .rst_ni, .step_i(step_w), .clr_i(hist_clr), .carry_i(carry_w), .corr_o(corr_w)
  );

  assign div_nxt = {1'b0, n_i} + {{(DIV_W-CORR_W){corr_w[CORR_W-1]}}, corr_w};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= take_w;
      if (take_w) div_o <= cfg_err_o ? {1'b0, n_i} : div_nxt;
    end
  end

  a_r2_valid_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_w |=> valid_o);
  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_w |=> !valid_o && $stable(div_o));
  a_r3_integer_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_w && order_i == '0 |=> div_o == {1'b0, $past(n_i)});
  a_r9_err_passes_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_w && cfg_err_o |=> div_o == {1'b0, $past(n_i)});
endmodule

// File: tb/frac_mash_ctrl_tb_top.sv
module frac_mash_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, stb = 1'b0, mrst = 1'b0;
  logic [18:0] n = '0;
  logic [31:0] num = '0, den = '0;
  logic [2:0]  ord = '0;
  logic [19:0] div;
  logic        vld, cerr;

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  longint unsigned ms [4];
  longint hist [4][3];
  longint rec [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_mash_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_stb_i(stb), .mod_rst_i(mrst),
    .n_i(n), .num_i(num), .den_i(den), .order_i(ord),
    .div_o(div), .valid_o(vld), .cfg_err_o(cerr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ref_err(input int o, input longint nn, input longint nu, input longint de);
    int m = (o == 0) ? 0 : ((1 << (o - 1)) - 1);
    if (o > 4) return 1'b1;
    if (nn < 28 + m) return 1'b1;
    if (o > 0 && (de == 0 || nu >= de)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 4; k++) begin
      ms[k] = 0;
      for (int h = 0; h < 3; h++) hist[k][h] = 0;
    end
  endtask

  // accumulator cascade plus expanded difference sum
  task automatic model_step(input int o, input longint nn, input longint nu,
                            input longint de, output longint e);
    longint unsigned add, s;
    longint c [4];
    longint y;
    if (ref_err(o, nn, nu, de)) begin
      model_clear();
      e = nn;
      return;
    end
    add = nu;
    for (int k = 0; k < 4; k++) begin
      c[k] = 0;
      if (k < o) begin
        s = ms[k] + add;
        if (s >= de) begin c[k] = 1; s = s - de; end
        ms[k] = s;
        add = s;
      end else ms[k] = 0;
    end
    y = c[0] + (c[1] - hist[1][0]) + (c[2] - 2*hist[2][0] + hist[2][1])
      + (c[3] - 3*hist[3][0] + 3*hist[3][1] - hist[3][2]);
    for (int k = 0; k < 4; k++) begin
      hist[k][2] = hist[k][1];
      hist[k][1] = hist[k][0];
      hist[k][0] = c[k];
    end
    e = nn + y;
  endtask

  task automatic strobe(input int o, input longint nn, input longint nu, input longint de,
                        input string tag, output longint got);
    longint e;
    int gap;
    @(negedge clk) stb = 1'b1;
    @(negedge clk) stb = 1'b0;
    model_step(o, nn, nu, de, e);
    got = longint'(div);
    chk(vld == 1'b1, "R2", longint'(vld), 1);
    chk(got == e, tag, got, e);
    gap = int'($urandom_range(0, 2));
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(vld == 1'b0 && longint'(div) == got, "R2", longint'(div), got);
    end
  endtask

  // mode 0 plain, 1 record first outputs, 2 compare against recording
  task automatic run_cfg(input int o, input longint nn, input longint nu, input longint de,
                         input int len, input string tag, input int mode);
    longint got, sum, d, lim;
    bit e_err;
    @(negedge clk);
    ord = 3'(o); n = 19'(nn); num = 32'(nu); den = 32'(de); mrst = 1'b1;
    #1;
    e_err = ref_err(o, nn, nu, de);
    chk(cerr == e_err, tag, longint'(cerr), longint'(e_err));
    @(negedge clk) mrst = 1'b0;
    model_clear();
    sum = 0;
    for (int i = 0; i < len; i++) begin
      strobe(o, nn, nu, de, tag, got);
      sum += got;
      if (mode == 1 && i < 32) rec[i] = got;
      if (mode == 2 && i < 32) chk(got == rec[i], "R12", got, rec[i]);
    end
    if (!e_err && o >= 1) begin
      d = de * (sum - longint'(len) * nn) - longint'(len) * nu;
      if (o == 1) begin
        if (len % de == 0) chk(d == 0, "R6", d, 0);
        else chk(d <= 0 && d > -de, "R6", d, 0);
      end else begin
        lim = de * (longint'(1) << (o - 2));
        chk(d > -lim && d <= lim, "R7", d, lim);
      end
    end
  endtask

  initial begin
    longint held, rn, rd;
    int ro;
    void'($urandom(32'd31337));
    model_clear();
    repeat (3) @(negedge clk);
    chk(div == '0, "R1", longint'(div), 0);
    chk(vld == 1'b0, "R1", longint'(vld), 0);
    rst_n = 1'b1;

    run_cfg(1, 100, 1, 3, 300, "R6", 0);
    run_cfg(1, 50, 7, 1000, 1000, "R6", 0);
    run_cfg(2, 60, 1, 3, 200, "R5", 0);
    run_cfg(3, 60, 2, 7, 200, "R5", 0);
    run_cfg(4, 100, 1, 3, 243, "R5", 0);
    run_cfg(4, 200, 7, 1000, 400, "R7", 0);
    run_cfg(4, 524287, 64'h8000_0001, 64'hFFFF_FFFF, 200, "R13", 0);
    run_cfg(3, 1000, 64'hFFFF_FFF0, 64'hFFFF_FFFF, 100, "R4", 0);
    run_cfg(0, 77, 5, 3, 20, "R3", 0);
    run_cfg(0, 90, 9, 0, 20, "R3", 0);
    run_cfg(3, 40, 0, 1, 30, "R8", 0);
    run_cfg(4, 40, 0, 1, 30, "R8", 0);
    run_cfg(2, 100, 5, 5, 20, "R9", 0);
    run_cfg(4, 100, 1, 0, 20, "R9", 0);
    run_cfg(4, 34, 1, 3, 20, "R10", 0);
    run_cfg(4, 35, 1, 3, 40, "R10", 0);
    run_cfg(0, 27, 0, 1, 10, "R10", 0);
    run_cfg(0, 28, 0, 1, 10, "R10", 0);
    run_cfg(5, 100, 1, 3, 10, "R11", 0);
    run_cfg(7, 100, 1, 3, 10, "R11", 0);

    for (int i = 0; i < 8; i++) begin
      ro = int'($urandom_range(1, 4));
      rd = (i % 2 == 0) ? longint'($urandom_range(2, 50)) : longint'($urandom_range(1000, 32'hFFFF_FFFF));
      rn = longint'($urandom) % rd;
      run_cfg(ro, longint'($urandom_range(35, 524287)), rn, rd, 150, "R5", 0);
    end

    // R12: record, strobe during modulator reset, replay
    run_cfg(4, 100, 3, 11, 32, "R12", 1);
    held = longint'(div);
    @(negedge clk) begin stb = 1'b1; mrst = 1'b1; end
    @(negedge clk) begin stb = 1'b0; mrst = 1'b0; end
    chk(vld == 1'b0, "R12", longint'(vld), 0);
    chk(longint'(div) == held, "R12", longint'(div), held);
    run_cfg(4, 100, 3, 11, 32, "R12", 2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule